// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is a small bank of board control and status registers reached through a plain 32-bit register port. Software writes and reads word offsets to drive LEDs, keep set/clear flag words and program a display-control word. It can also read an identification value and the live state of two card-slot pins. A reset control register can request a board reset, but it only accepts writes while a 16-bit unlock key sits in the lock register.

A write takes effect at the clock edge where the write enable is sampled. Read data is registered at the edge where the read enable is sampled and is held until the next read. An access to an offset the bank does not decode returns zero and produces a one-cycle error strobe. An elaboration parameter selects the board variant. The variant sets which data bit of an accepted reset write requests a reset, which card-status bit carries the write-protect pin, and whether the display mux output is driven.

Top module: `sysctl_keyed_bank`

## Requirements
- R1: A read of offset 0x00 returns the ID_VALUE parameter. A read of offset 0x88 returns 0xFF000000. Reads of offsets 0x04, 0x4C, 0x54, 0x58 and 0x60 return 0 and raise no error.
- R2: A write of exactly 0x0000A05F to the lock register at 0x20 stores 0xA05F. Any other write stores data[15:0] AND 0x7FFF, so bit 15 reads 1 only while the key is held. A read of 0x20 returns the stored 16-bit value, zero-extended.
- R3: On variants A and B, a write to 0x40 is stored as the reset level only while the lock register holds 0xA05F. Otherwise the register keeps its old value. A read of 0x40 returns the reset level.
- R4: An accepted reset write with data bit 8 set (variant A) or data bit 2 set (variant B) drives resetReq high for exactly the one cycle after the write edge. No other write pulses resetReq.
- R5: On variant C, offset 0x40 reads 0, ignores writes and never pulses resetReq. Such an access raises no error.
- R6: A write to 0x30 ORs the data into the flags word. A write to 0x34 clears the flag bits that are set in the data. A read of 0x30 returns the flags.
- R7: Offsets 0x38 (set) and 0x3C (clear) act the same way on a second flags word, which a read of 0x38 returns. This word keeps its value through reset.
- R8: The display-control register at 0x50 resets to 0x00001F00. Its bits 13:8 ignore writes, and all of its other bits take the written data.
- R9: On variant A, muxCtrl equals display-control bits 1:0. On variants B and C, muxCtrl is 0.
- R10: A read of 0x48 returns cardPresent in bit 0 and writeProtect in bit 2 on variants A and C, or in bit 1 on variant B. All other bits are 0.
- R11: A write to 0x08 sets the LED register: ledOut and a read of 0x08 give data[LED_W-1:0]. Offsets 0x28 and 0x2C are two 32-bit config data registers that read back what was written.
- R12: After reset, the LED, lock, flags, reset level and both config data registers read 0, and ledOut, muxCtrl, resetReq and badAccess are 0.
- R13: A read of an offset outside the read map (which includes 0x34, 0x3C and any offset not listed above) returns 0. A write outside the write map (which includes 0x00, 0x48 and 0x88) changes no register. Either access drives badAccess high for exactly the one cycle after the access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request, sampled at the rising edge |
| rdEn | input | 1 | Read request, sampled at the rising edge |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data of the last read |
| badAccess | output | 1 | One-cycle strobe after an undecoded access |
| cardPresent | input | 1 | Card-present pin |
| writeProtect | input | 1 | Card write-protect pin |
| ledOut | output | LED_W | LED register contents |
| muxCtrl | output | 2 | Display format mux control (variant A) |
| resetReq | output | 1 | One-cycle reset request pulse |

## Verification
Several rules are checked on every cycle. Bit 15 of the lock word may only be set while the whole word equals the key. A reset pulse may only follow a cycle in which the key was held. Bits 13:8 of the display word must never change, and every set bit of a flags write must be present in the flags word afterwards. An error strobe must always be traced back to an access on the port. The other rules can only be shown by the bench's scenarios. These are the exact values held after masked lock writes, the rejection of a reset write without the key, and which data bit pulses the reset on each variant. They also include the write-protect bit position and survival of the second flags word across reset. Three variants are instantiated side by side on one bus for this.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {VAR_A, VAR_B, VAR_C} variant_e;

  localparam logic [15:0]       KEY_VALUE    = 16'hA05F;
  localparam logic [DATA_W-1:0] DISP_RESET   = 32'h0000_1F00;
  localparam logic [DATA_W-1:0] DISP_RO_MASK = 32'h0000_3F00;
  localparam logic [DATA_W-1:0] PROC2_VALUE  = 32'hFF00_0000;

  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_SWITCH = 8'h04;
  localparam logic [7:0] OFF_LED    = 8'h08;
  localparam logic [7:0] OFF_LOCK   = 8'h20;
  localparam logic [7:0] OFF_CFG1   = 8'h28;
  localparam logic [7:0] OFF_CFG2   = 8'h2C;
  localparam logic [7:0] OFF_FSET   = 8'h30;
  localparam logic [7:0] OFF_FCLR   = 8'h34;
  localparam logic [7:0] OFF_NVSET  = 8'h38;
  localparam logic [7:0] OFF_NVCLR  = 8'h3C;
  localparam logic [7:0] OFF_RESET  = 8'h40;
  localparam logic [7:0] OFF_CARD   = 8'h48;
  localparam logic [7:0] OFF_FLASH  = 8'h4C;
  localparam logic [7:0] OFF_DISP   = 8'h50;
  localparam logic [7:0] OFF_SERIAL = 8'h54;
  localparam logic [7:0] OFF_BOOT   = 8'h58;
  localparam logic [7:0] OFF_MISC   = 8'h60;
  localparam logic [7:0] OFF_PROC2  = 8'h88;

  typedef enum logic [3:0] {
    RS_ZERO, RS_ID, RS_LED, RS_LOCK, RS_CFG1, RS_CFG2, RS_FLAGS,
    RS_NVFLAGS, RS_RESET, RS_CARD, RS_DISP, RS_PROC2
  } rd_sel_e;

  typedef struct packed {
    logic    wrLed;
    logic    wrLock;
    logic    wrCfg1;
    logic    wrCfg2;
    logic    setFlags;
    logic    clrFlags;
    logic    setNv;
    logic    clrNv;
    logic    wrReset;
    logic    wrDisp;
    logic    rdStb;
    rd_sel_e rdSel;
    logic    bad;
  } ctrl_strobe_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter variant_e VARIANT = VAR_A,
  parameter int       ADDR_W  = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrl_strobe_t      stb
);

  logic       hiZero;
  logic [7:0] off;
  logic       wrBad;
  logic       rdBad;

  localparam logic HAS_RESET = (VARIANT != VAR_C);

  generate
    if (ADDR_W > 8) begin : g_hi
      assign hiZero = ~|addr[ADDR_W-1:8];
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  assign off = addr[7:0];

  always_comb begin
    stb       = '0;
    stb.rdSel = RS_ZERO;
    wrBad     = 1'b0;
    rdBad     = 1'b0;

    if (wrEn) begin
      if (!hiZero) begin
        wrBad = 1'b1;
      end else begin
        case (off)
          OFF_LED:    stb.wrLed    = 1'b1;
          OFF_LOCK:   stb.wrLock   = 1'b1;
          OFF_CFG1:   stb.wrCfg1   = 1'b1;
          OFF_CFG2:   stb.wrCfg2   = 1'b1;
          OFF_FSET:   stb.setFlags = 1'b1;
          OFF_FCLR:   stb.clrFlags = 1'b1;
          OFF_NVSET:  stb.setNv    = 1'b1;
          OFF_NVCLR:  stb.clrNv    = 1'b1;
          OFF_RESET:  stb.wrReset  = HAS_RESET;
          OFF_DISP:   stb.wrDisp   = 1'b1;
          OFF_FLASH, OFF_SERIAL: ;
          default:    wrBad        = 1'b1;
        endcase
      end
    end

    if (rdEn) begin
      stb.rdStb = 1'b1;
      if (!hiZero) begin
        rdBad = 1'b1;
      end else begin
        case (off)
          OFF_ID:     stb.rdSel = RS_ID;
          OFF_LED:    stb.rdSel = RS_LED;
          OFF_LOCK:   stb.rdSel = RS_LOCK;
          OFF_CFG1:   stb.rdSel = RS_CFG1;
          OFF_CFG2:   stb.rdSel = RS_CFG2;
          OFF_FSET:   stb.rdSel = RS_FLAGS;
          OFF_NVSET:  stb.rdSel = RS_NVFLAGS;
          OFF_RESET:  stb.rdSel = HAS_RESET ? RS_RESET : RS_ZERO;
          OFF_CARD:   stb.rdSel = RS_CARD;
          OFF_DISP:   stb.rdSel = RS_DISP;
          OFF_PROC2:  stb.rdSel = RS_PROC2;
          OFF_SWITCH, OFF_FLASH, OFF_SERIAL, OFF_BOOT, OFF_MISC:
                      stb.rdSel = RS_ZERO;
          default:    rdBad     = 1'b1;
        endcase
      end
    end

    stb.bad = wrBad | rdBad;
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter variant_e          VARIANT  = VAR_A,
  parameter int                LED_W    = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cardPresent,
  input  logic              writeProtect,
  output logic [DATA_W-1:0] rdData,
  output logic              badAccess,
  output logic [LED_W-1:0]  ledOut,
  output logic [1:0]        muxCtrl,
  output logic              resetReq
);

  localparam int RST_BIT = (VARIANT == VAR_A) ? 8 : 2;
  localparam int WP_BIT  = (VARIANT == VAR_B) ? 1 : 2;

  logic [LED_W-1:0]  ledReg;
  logic [15:0]       lockReg;
  logic [DATA_W-1:0] cfg1Reg;
  logic [DATA_W-1:0] cfg2Reg;
  logic [DATA_W-1:0] flagsReg;
  logic [DATA_W-1:0] nvFlagsReg;
  logic [DATA_W-1:0] resetLevel;
  logic [DATA_W-1:0] dispReg;
  logic [DATA_W-1:0] cardWord;
  logic [DATA_W-1:0] rdNext;
  logic              keyHeld;
  logic              resetAccept;

  assign keyHeld     = (lockReg == KEY_VALUE);
  assign resetAccept = stb.wrReset && keyHeld;

  always_comb begin
    cardWord         = '0;
    cardWord[0]      = cardPresent;
    cardWord[WP_BIT] = writeProtect;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ledReg     <= '0;
      lockReg    <= '0;
      cfg1Reg    <= '0;
      cfg2Reg    <= '0;
      flagsReg   <= '0;
      resetLevel <= '0;
      dispReg    <= DISP_RESET;
    end else begin
      if (stb.wrLed)  ledReg  <= wrData[LED_W-1:0];
      if (stb.wrLock) lockReg <= (wrData == DATA_W'(KEY_VALUE)) ? KEY_VALUE
                                 : (wrData[15:0] & 16'h7FFF);
      if (stb.wrCfg1) cfg1Reg <= wrData;
      if (stb.wrCfg2) cfg2Reg <= wrData;
      if (stb.setFlags)      flagsReg <= flagsReg | wrData;
      else if (stb.clrFlags) flagsReg <= flagsReg & ~wrData;
      if (resetAccept) resetLevel <= wrData;
      if (stb.wrDisp)  dispReg <= (dispReg & DISP_RO_MASK) | (wrData & ~DISP_RO_MASK);
    end
  end

  // Second flag word is deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (stb.setNv)      nvFlagsReg <= nvFlagsReg | wrData;
    else if (stb.clrNv) nvFlagsReg <= nvFlagsReg & ~wrData;
  end

  always_comb begin
    case (stb.rdSel)
      RS_ID:      rdNext = ID_VALUE;
      RS_LED:     rdNext = DATA_W'(ledReg);
      RS_LOCK:    rdNext = DATA_W'(lockReg);
      RS_CFG1:    rdNext = cfg1Reg;
      RS_CFG2:    rdNext = cfg2Reg;
      RS_FLAGS:   rdNext = flagsReg;
      RS_NVFLAGS: rdNext = nvFlagsReg;
      RS_RESET:   rdNext = resetLevel;
      RS_CARD:    rdNext = cardWord;
      RS_DISP:    rdNext = dispReg;
      RS_PROC2:   rdNext = PROC2_VALUE;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData    <= '0;
      badAccess <= 1'b0;
      resetReq  <= 1'b0;
    end else begin
      if (stb.rdStb) rdData <= rdNext;
      badAccess <= stb.bad;
      resetReq  <= resetAccept && wrData[RST_BIT];
    end
  end

  assign ledOut = ledReg;

  generate
    if (VARIANT == VAR_A) begin : g_mux
      assign muxCtrl = dispReg[1:0];
    end else begin : g_nomux
      assign muxCtrl = 2'b00;
    end
  endgenerate

  // R2: bit 15 of the lock word only ever set together with the full key
  assert_lock_bit15_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lockReg[15] |-> (lockReg == KEY_VALUE));

  // R3 / R4: a reset pulse only follows a cycle in which the key was held
  assert_reset_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |-> ($past(lockReg) == KEY_VALUE));

  // R8: read-only display bits never move
  assert_disp_ro_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dispReg[13:8]));

  // R6: every bit of a flag-set write is present afterwards
  assert_flags_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.setFlags |=> ((flagsReg & $past(wrData)) == $past(wrData)));

endmodule

// File: rtl/sysctl_keyed_bank.sv
module sysctl_keyed_bank
  import sysctl_pkg::*;
#(
  parameter variant_e          VARIANT  = VAR_A,
  parameter int                ADDR_W   = 8,
  parameter int                LED_W    = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0C05_1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              badAccess,
  input  logic              cardPresent,
  input  logic              writeProtect,
  output logic [LED_W-1:0]  ledOut,
  output logic [1:0]        muxCtrl,
  output logic              resetReq
);

  ctrl_strobe_t stb;

  sysctl_ctrl #(
    .VARIANT(VARIANT),
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .stb (stb)
  );

  sysctl_regs #(
    .VARIANT (VARIANT),
    .LED_W   (LED_W),
    .ID_VALUE(ID_VALUE)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .wrData      (wrData),
    .cardPresent (cardPresent),
    .writeProtect(writeProtect),
    .rdData      (rdData),
    .badAccess   (badAccess),
    .ledOut      (ledOut),
    .muxCtrl     (muxCtrl),
    .resetReq    (resetReq)
  );

  // R13: an error strobe always traces back to an access on the port
  assert_bad_has_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
    badAccess |-> $past(wrEn || rdEn));

endmodule

// File: tb/sysctl_keyed_bank_tb.sv
module sysctl_keyed_bank_tb_top;
  import sysctl_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] IDV        = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        cardPresent = 1'b0;
  logic        writeProtect = 1'b0;

  logic [31:0] rdA, rdB, rdC;
  logic        badA, badB, badC;
  logic [7:0]  ledA, ledB, ledC;
  logic [1:0]  muxA, muxB, muxC;
  logic        rstA, rstB, rstC;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_keyed_bank #(.VARIANT(VAR_A), .ID_VALUE(IDV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdA), .badAccess(badA), .cardPresent(cardPresent), .writeProtect(writeProtect),
    .ledOut(ledA), .muxCtrl(muxA), .resetReq(rstA));

  sysctl_keyed_bank #(.VARIANT(VAR_B), .ID_VALUE(IDV)) dutB_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdB), .badAccess(badB), .cardPresent(cardPresent), .writeProtect(writeProtect),
    .ledOut(ledB), .muxCtrl(muxB), .resetReq(rstB));

  sysctl_keyed_bank #(.VARIANT(VAR_C), .ID_VALUE(IDV)) dutC_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdC), .badAccess(badC), .cardPresent(cardPresent), .writeProtect(writeProtect),
    .ledOut(ledC), .muxCtrl(muxC), .resetReq(rstC));

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h00, 32'h0, IDV,           4'd1},  // R1 id
    '{1'b0, 8'h88, 32'h0, 32'hFF00_0000, 4'd1},  // R1 second proc id
    '{1'b0, 8'h04, 32'h0, 32'h0,         4'd1},  // R1 switches
    '{1'b1, 8'h08, 32'h0000_015A, 32'h0, 4'd11}, // R11 led write
    '{1'b0, 8'h08, 32'h0, 32'h0000_005A, 4'd11}, // R11 led read
    '{1'b1, 8'h20, 32'h1234_F00F, 32'h0, 4'd2},  // R2 masked lock
    '{1'b0, 8'h20, 32'h0, 32'h0000_700F, 4'd2},  // R2
    '{1'b1, 8'h40, 32'h0000_0003, 32'h0, 4'd3},  // R3 locked: rejected
    '{1'b0, 8'h40, 32'h0, 32'h0,         4'd3},  // R3
    '{1'b1, 8'h20, 32'h0000_A05F, 32'h0, 4'd2},  // R2 key
    '{1'b0, 8'h20, 32'h0, 32'h0000_A05F, 4'd2},  // R2
    '{1'b1, 8'h40, 32'h0000_00F0, 32'h0, 4'd3},  // R3 unlocked: accepted
    '{1'b0, 8'h40, 32'h0, 32'h0000_00F0, 4'd3},  // R3
    '{1'b1, 8'h30, 32'h0000_00F1, 32'h0, 4'd6},  // R6 set
    '{1'b1, 8'h34, 32'h0000_0031, 32'h0, 4'd6},  // R6 clear
    '{1'b0, 8'h30, 32'h0, 32'h0000_00C0, 4'd6},  // R6
    '{1'b1, 8'h50, 32'hFFFF_FFFF, 32'h0, 4'd8},  // R8 display write
    '{1'b0, 8'h50, 32'h0, 32'hFFFF_DFFF, 4'd8},  // R8
    '{1'b1, 8'h28, 32'hCAFE_0001, 32'h0, 4'd11}, // R11 config data
    '{1'b0, 8'h28, 32'h0, 32'hCAFE_0001, 4'd11}, // R11
    '{1'b0, 8'h2C, 32'h0, 32'h0,         4'd11}  // R11 second config data
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] o, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = o; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] o);
    @(negedge clk);
    rdEn = 1'b1; addr = o;
    @(posedge clk);
    #1;
    rdEn = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 ledOut", 32'(ledA), 32'h0);
    chk("R12 resetReq", 32'(rstA), 32'h0);
    chk("R12 badAccess", 32'(badA), 32'h0);
    chk("R12 muxCtrl", 32'(muxA), 32'h0);
    doRead(8'h20); chk("R12 lock", rdA, 32'h0);
    doRead(8'h30); chk("R12 flags", rdA, 32'h0);
    doRead(8'h40); chk("R12 reset level", rdA, 32'h0);
    doRead(8'h28); chk("R12 cfg1", rdA, 32'h0);
    doRead(8'h08); chk("R12 led reg", rdA, 32'h0);
    doRead(8'h50); chk("R8 display reset", rdA, 32'h0000_1F00);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) begin
        doWrite(VEC[i].off, VEC[i].data);
      end else begin
        doRead(VEC[i].off);
        checks++;
        if (rdA !== VEC[i].expv) begin
          failures++;
          $display("FAIL R%0d vec %0d actual=0x%08h expected=0x%08h",
                   VEC[i].req, i, rdA, VEC[i].expv);
        end
      end
    end
    chk("R11 ledOut", 32'(ledA), 32'h0000_005A);
    chk("R9 mux after all-ones", 32'(muxA), 32'h3);

    // R1 zero-reading offsets, no error
    doRead(8'h60); chk("R1 misc", rdA, 32'h0); chk("R1 no error", 32'(badA), 32'h0);
    doRead(8'h58); chk("R1 boot", rdA, 32'h0);

    // R4 variant-specific pulse bit (key still held)
    doWrite(8'h40, 32'h0000_0100);
    chk("R4 A pulse bit8", 32'(rstA), 32'h1);
    chk("R4 B no pulse bit8", 32'(rstB), 32'h0);
    chk("R5 C no pulse", 32'(rstC), 32'h0);
    @(posedge clk); #1;
    chk("R4 A single cycle", 32'(rstA), 32'h0);
    doWrite(8'h40, 32'h0000_0004);
    chk("R4 B pulse bit2", 32'(rstB), 32'h1);
    chk("R4 A no pulse bit2", 32'(rstA), 32'h0);
    doRead(8'h40);
    chk("R4 B not sustained", 32'(rstB), 32'h0);
    chk("R3 A level", rdA, 32'h4);
    chk("R3 B level", rdB, 32'h4);
    chk("R5 C reads zero", rdC, 32'h0);
    chk("R5 C no error", 32'(badC), 32'h0);

    // R2 near-key value, then R3 rejection after relock
    doWrite(8'h20, 32'h0001_A05F);
    doRead(8'h20); chk("R2 near key", rdA, 32'h0000_205F);
    doWrite(8'h40, 32'h0000_0155);
    chk("R4 no pulse when locked", 32'(rstA), 32'h0);
    doRead(8'h40); chk("R3 locked keeps level", rdA, 32'h4);

    // R9 mux
    doWrite(8'h50, 32'h0000_0002);
    chk("R9 A mux", 32'(muxA), 32'h2);
    chk("R9 B mux", 32'(muxB), 32'h0);
    doRead(8'h50); chk("R8 ro bits kept", rdA, 32'h0000_1F02);

    // R10 card status
    cardPresent = 1'b1; writeProtect = 1'b1;
    doRead(8'h48);
    chk("R10 A card", rdA, 32'h5);
    chk("R10 B card", rdB, 32'h3);
    chk("R10 C card", rdC, 32'h5);
    cardPresent = 1'b0;
    doRead(8'h48);
    chk("R10 A wp only", rdA, 32'h4);
    chk("R10 B wp only", rdB, 32'h2);

    // R13 undecoded accesses
    doRead(8'hFC);
    chk("R13 read zero", rdA, 32'h0);
    chk("R13 bad strobe", 32'(badA), 32'h1);
    @(posedge clk); #1;
    chk("R13 strobe one cycle", 32'(badA), 32'h0);
    doRead(8'h34); chk("R13 clear offset read", 32'(badA), 32'h1);
    doWrite(8'h48, 32'hFFFF_FFFF); chk("R13 write ro offset", 32'(badA), 32'h1);
    doWrite(8'h00, 32'hFFFF_FFFF); chk("R13 write id offset", 32'(badA), 32'h1);
    doRead(8'h00); chk("R13 id unchanged", rdA, IDV);

    // R7 non-volatile flags survive reset
    doWrite(8'h3C, 32'hFFFF_FFFF);
    doWrite(8'h38, 32'h0000_0811);
    doWrite(8'h3C, 32'h0000_0800);
    doRead(8'h38); chk("R7 set/clear", rdA, 32'h0000_0011);
    pulseReset();
    doRead(8'h38); chk("R7 kept through reset", rdA, 32'h0000_0011);
    doRead(8'h30); chk("R12 flags cleared", rdA, 32'h0);
    doRead(8'h20); chk("R12 lock cleared", rdA, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule